// File: doc/BRIEF.md
# Key-protected clock and power controller

A small register unit holding two settings: a clock-configuration register and a power-control register. Software cannot change either with a single store. Each register has a three-step unlock. The first step is a write of a fixed code to that register's first key address. The second step is a write of the new value to the register itself. The third step is a write of a second fixed code to its second key address. Any other bus write placed among these steps cancels the sequence, and the staged value is dropped.

The unit drives four results from the committed fields: the 32 kHz source select, the clock mode, the operating mode, and a CPU clock-enable strobe. The strobe fires once every 2^CD base cycles. Four interrupt lines and a timer line can pull the unit out of the low-power modes. In sleep mode, any of the five lines wakes it. In stop mode, only the interrupt lines do.

Word address map on `addr_i`:

| Address | Use |
|---|---|
| 0 | clock key A |
| 1 | clock configuration |
| 2 | clock key B |
| 3 | power key A |
| 4 | power control |
| 5 | power key B |

Addresses 6 and 7 are unused.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, address 1 reads 0x0021 and address 4 reads 0x0003. At the same time osc_int_o is 1, clk_mode_o is 01 and op_mode_o is 000.
- R2: The clock register takes the staged value on the edge of this exact sequence of writes: 0x00AA to address 0, then the value to address 1, then 0x0055 to address 2. Address 1 reads back {10'b0, bit5, 3'b0, bits[1:0]}.
- R3: The power register takes the staged value on the edge of this exact sequence of writes: 0x0001 to address 3, then the value to address 4, then 0x00F4 to address 5. Address 4 reads back {9'b0, bits[6:4], 1'b0, bits[2:0]}.
- R4: A write to a wrong address or with a wrong key code, placed anywhere inside a sequence, aborts it. A following closing key write then changes nothing.
- R5: Addresses 0, 2, 3, 5, 6 and 7 always read 0x0000.
- R6: Clock-mode codes 00 and 10 are reserved. A committed value that carries one of them keeps the old clock mode. Bit 5 is still updated (1 = internal oscillator, 0 = external crystal).
- R7: Operating-mode codes 101, 110 and 111 are reserved. A committed value that carries one of them keeps the old mode. The divider field is still updated.
- R8: cpu_clk_en_o is high for one cycle in every 2^CD cycles. With CD=0 it is high every cycle. The first pulse after reset comes on the 8th cycle, because the reset value of CD is 3.
- R9: A new CD value is taken up only on the cycle that ends the current period. No period is cut short.
- R10: In sleep mode (011), a high level on any irq_i line or on tmr_i returns op_mode_o to 000 one edge later.
- R11: In stop mode (100), only irq_i wakes the unit, and tmr_i has no effect. In active, pause (001) and nap (010) modes, irq_i and tmr_i do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | base clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| we_i | input | 1 | write strobe |
| addr_i | input | 3 | word address |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data for addr_i, combinational |
| irq_i | input | 4 | external interrupt wake lines |
| tmr_i | input | 1 | timer wake line |
| osc_int_o | output | 1 | 1 = internal 32 kHz oscillator, 0 = external crystal |
| clk_mode_o | output | 2 | 01 = PLL, 11 = external clock pin |
| op_mode_o | output | 3 | operating mode |
| cpu_clk_en_o | output | 1 | CPU clock-enable strobe |

## Verification
The hardest case to reach is a divider change that lands in the middle of a long period. The new CD must wait for the old period to finish, and the bench can only see this as the spacing of strobes. The stimulus commits CD=5, lets it run, then commits CD=1 partway through a 32-cycle period and watches the strobe every cycle. A second hard case is the set of sequences broken at each step. These are a wrong key code, a write to the other register's key address, and a closing key written alone. After each one the bench reads the register back. The wake tests enter sleep, stop, pause and nap through full unlock sequences, then pulse the timer and the interrupt lines separately.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CD_W   = 3;

  localparam logic [ADDR_W-1:0] A_CLK_K1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLK_K2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_PWR_K1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_PWR    = 3'd4;
  localparam logic [ADDR_W-1:0] A_PWR_K2 = 3'd5;

  localparam logic [DATA_W-1:0] CLK_KEY1 = 16'h00AA;
  localparam logic [DATA_W-1:0] CLK_KEY2 = 16'h0055;
  localparam logic [DATA_W-1:0] PWR_KEY1 = 16'h0001;
  localparam logic [DATA_W-1:0] PWR_KEY2 = 16'h00F4;

  typedef enum logic [2:0] {
    OP_ACTIVE = 3'b000,
    OP_PAUSE  = 3'b001,
    OP_NAP    = 3'b010,
    OP_SLEEP  = 3'b011,
    OP_STOP   = 3'b100
  } op_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_KEYED,
    SEQ_STAGED
  } seq_state_e;
endpackage

// File: rtl/key_seq.sv
module key_seq
  import clk_pwr_pkg::*;
#(
  parameter int unsigned      SW     = 3,
  parameter logic [ADDR_W-1:0] A_KEY1 = 3'd0,
  parameter logic [ADDR_W-1:0] A_DATA = 3'd1,
  parameter logic [ADDR_W-1:0] A_KEY2 = 3'd2,
  parameter logic [DATA_W-1:0] KEY1   = 16'h00AA,
  parameter logic [DATA_W-1:0] KEY2   = 16'h0055
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SW-1:0]     field_i,
  output logic              commit_o,
  output logic [SW-1:0]     staged_o
);
  seq_state_e state_q, state_d;
  logic [SW-1:0] stage_q;

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    if (we_i) begin
      state_d = SEQ_IDLE;  // any off-sequence write aborts
      unique case (state_q)
        SEQ_IDLE:   if (addr_i == A_KEY1 && wdata_i == KEY1) state_d = SEQ_KEYED;
        SEQ_KEYED:  if (addr_i == A_DATA) state_d = SEQ_STAGED;
        SEQ_STAGED: commit_o = (addr_i == A_KEY2 && wdata_i == KEY2);
        default:    state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      stage_q <= '0;
    end else begin
      state_q <= state_d;
      if (we_i && state_q == SEQ_KEYED && addr_i == A_DATA) stage_q <= field_i;
    end
  end

  assign staged_o = stage_q;

  // R4: a commit needs a staged state reached on an earlier write
  a_r4_commit_needs_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> state_q == SEQ_STAGED && we_i);
endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div #(
  parameter int unsigned CD_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CD_W-1:0] cd_i,
  output logic            en_o
);
  localparam int unsigned CNT_W = (1 << CD_W) - 1;
  localparam logic [CD_W-1:0] CD_RST = CD_W'(3);

  logic [CNT_W-1:0] cnt_q, lim;
  logic [CD_W-1:0]  cd_act_q;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(cd_act_q));
  end

  assign en_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      cd_act_q <= CD_RST;
    end else if (en_o) begin
      cnt_q    <= '0;
      cd_act_q <= cd_i;  // divider changes only at wrap
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r9_change_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cd_act_q) |-> $past(en_o));
  a_r8_restart_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> cnt_q == '0);
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [3:0]        irq_i,
  input  logic              tmr_i,
  output logic              osc_int_o,
  output logic [1:0]        clk_mode_o,
  output logic [2:0]        op_mode_o,
  output logic              cpu_clk_en_o
);
  logic       clk_commit, pwr_commit;
  logic [2:0] clk_staged;
  logic [5:0] pwr_staged;
  logic       osel_q;
  logic [1:0] cmode_q;
  op_mode_e   op_q;
  logic [CD_W-1:0] cd_q;
  logic       wake;

  key_seq #(.SW(3), .A_KEY1(A_CLK_K1), .A_DATA(A_CLK), .A_KEY2(A_CLK_K2),
            .KEY1(CLK_KEY1), .KEY2(CLK_KEY2)) u_clk_seq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .field_i ({wdata_i[5], wdata_i[1:0]}),
    .commit_o(clk_commit), .staged_o(clk_staged));

  key_seq #(.SW(6), .A_KEY1(A_PWR_K1), .A_DATA(A_PWR), .A_KEY2(A_PWR_K2),
            .KEY1(PWR_KEY1), .KEY2(PWR_KEY2)) u_pwr_seq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .field_i ({wdata_i[6:4], wdata_i[2:0]}),
    .commit_o(pwr_commit), .staged_o(pwr_staged));

  assign wake = (op_q == OP_SLEEP && (|irq_i || tmr_i)) ||
                (op_q == OP_STOP && |irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osel_q  <= 1'b1;
      cmode_q <= 2'b01;
      op_q    <= OP_ACTIVE;
      cd_q    <= CD_W'(3);
    end else begin
      if (clk_commit) begin
        osel_q <= clk_staged[2];
        if (clk_staged[0]) cmode_q <= clk_staged[1:0];  // 01 / 11 only
      end
      if (pwr_commit) cd_q <= pwr_staged[2:0];
      if (wake) op_q <= OP_ACTIVE;
      else if (pwr_commit && pwr_staged[5:3] <= 3'd4) op_q <= op_mode_e'(pwr_staged[5:3]);
    end
  end

  cpu_clk_div #(.CD_W(CD_W)) u_div (.clk_i, .rst_ni, .cd_i(cd_q), .en_o(cpu_clk_en_o));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CLK:   rdata_o = {10'b0, osel_q, 3'b0, cmode_q};
      A_PWR:   rdata_o = {9'b0, op_q, 1'b0, cd_q};
      default: rdata_o = '0;
    endcase
  end

  assign osc_int_o  = osel_q;
  assign clk_mode_o = cmode_q;
  assign op_mode_o  = op_q;

  a_r2_clk_key_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({osel_q, cmode_q}) |-> $past(we_i && addr_i == A_CLK_K2 && wdata_i == CLK_KEY2));
  a_r3_pwr_key_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cd_q) |-> $past(we_i && addr_i == A_PWR_K2 && wdata_i == PWR_KEY2));
  a_r6_cmode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mode_o == 2'b01 || clk_mode_o == 2'b11);
  a_r7_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_mode_o <= 3'd4);
  a_r10_sleep_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_mode_o == 3'd3 && (|irq_i || tmr_i)) |=> op_mode_o == 3'd0);
  a_r11_stop_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_mode_o == 3'd4 && |irq_i) |=> op_mode_o == 3'd0);
endmodule

// File: tb/clk_pwr_ctrl_tb.sv
module clk_pwr_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, tmr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  irq = '0;
  logic        osc_int, cpu_en;
  logic [1:0]  cmode;
  logic [2:0]  op;
  int checks = 0, errors = 0, cycles = 0;
  bit  done = 0;

  always #10 clk = ~clk;  // 50 MHz

  clk_pwr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .tmr_i(tmr), .osc_int_o(osc_int),
    .clk_mode_o(cmode), .op_mode_o(op), .cpu_clk_en_o(cpu_en));

  // behavioural model
  int m_cs = 0, m_ps = 0, m_cstg = 0, m_pstg = 0;
  int m_osel = 1, m_cm = 1, m_op = 0, m_cd = 3;
  int m_cnt = 0, m_cda = 3;

  function automatic int m_read(int a);
    if (a == 1) return (m_osel << 5) | m_cm;
    if (a == 4) return (m_op << 4) | m_cd;
    return 0;
  endfunction

  function automatic int seq_step(int st, int a, int d, int ak1, int ad, int k1, ref bit stage);
    stage = 0;
    if (st == 0) return (a == ak1 && d == k1) ? 1 : 0;
    if (st == 1 && a == ad) begin stage = 1; return 2; end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cs = 0; m_ps = 0; m_osel = 1; m_cm = 1; m_op = 0; m_cd = 3; m_cnt = 0; m_cda = 3;
    end else begin
      bit cc, pc, sc, sp, wk;
      int a, d;
      a = int'(addr); d = int'(wdata);
      cc = we && m_cs == 2 && a == 2 && d == 'h55;
      pc = we && m_ps == 2 && a == 5 && d == 'hF4;
      wk = (m_op == 3 && (irq != 0 || tmr)) || (m_op == 4 && irq != 0);
      if (m_cnt == (1 << m_cda) - 1) begin m_cnt = 0; m_cda = m_cd; end
      else m_cnt++;
      if (we) begin
        m_cs = seq_step(m_cs, a, d, 0, 1, 'hAA, sc);
        m_ps = seq_step(m_ps, a, d, 3, 4, 'h01, sp);
        if (sc) m_cstg = d;
        if (sp) m_pstg = d;
      end
      if (cc) begin
        m_osel = (m_cstg >> 5) & 1;
        if ((m_cstg & 3) == 1 || (m_cstg & 3) == 3) m_cm = m_cstg & 3;
      end
      if (pc) m_cd = m_pstg & 7;
      if (wk) m_op = 0;
      else if (pc && ((m_pstg >> 4) & 7) <= 4) m_op = (m_pstg >> 4) & 7;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8/R9 cpu_clk_en", int'(cpu_en), int'(m_cnt == (1 << m_cda) - 1));
    chk("R2/R6 osc_int", int'(osc_int), m_osel);
    chk("R2/R6 clk_mode", int'(cmode), m_cm);
    chk("R3/R7/R10/R11 op_mode", int'(op), m_op);
    chk("R1/R5 rdata", int'(rdata), m_read(int'(addr)));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2; we = 1; addr = 3'(a); wdata = 16'(d);
    @(posedge clk); #2; we = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic rd_chk(string tag, int a, int exp);
    @(posedge clk); #2; addr = 3'(a);
    @(negedge clk); chk(tag, int'(rdata), exp);
  endtask
  task automatic clk_seq(int v);  wr(0, 'hAA); wr(1, v); wr(2, 'h55); endtask
  task automatic pwr_seq(int v);  wr(3, 'h01); wr(4, v); wr(5, 'hF4); endtask

  initial begin
    #35; rst_n = 1;
    // R1: reset state
    rd_chk("R1 clk reg", 1, 'h21);
    rd_chk("R1 pwr reg", 4, 'h03);
    chk("R1 osc_int", int'(osc_int), 1);
    chk("R1 clk_mode", int'(cmode), 1);
    chk("R1 op_mode", int'(op), 0);
    idle(12);
    // R2
    clk_seq('h03);
    rd_chk("R2 clk commit", 1, 'h03);
    // R6
    clk_seq('h00);
    rd_chk("R6 reserved 00 kept", 1, 'h03);
    clk_seq('h22);
    rd_chk("R6 reserved 10 osel updated", 1, 'h23);
    // R4
    wr(0, 'hAA); wr(1, 'h21); wr(3, 'h01); wr(2, 'h55);
    rd_chk("R4 other address aborts", 1, 'h23);
    wr(0, 'hAB); wr(1, 'h21); wr(2, 'h55);
    rd_chk("R4 wrong key1", 1, 'h23);
    wr(0, 'hAA); wr(1, 'h21); wr(2, 'h56); wr(2, 'h55);
    rd_chk("R4 wrong key2 then lone key2", 1, 'h23);
    pwr_seq('h0000); wr(3, 'h01); wr(4, 'h0005); wr(4, 'h0005); wr(5, 'hF4);
    rd_chk("R4 repeated data write aborts", 4, 'h0000);
    // R5
    wr(0, 'hAA);
    rd_chk("R5 key addr 0", 0, 0);
    rd_chk("R5 key addr 2", 2, 0);
    rd_chk("R5 key addr 3", 3, 0);
    rd_chk("R5 key addr 5", 5, 0);
    rd_chk("R5 addr 6", 6, 0);
    rd_chk("R5 addr 7", 7, 0);
    // R3, R8
    pwr_seq('h0000);
    rd_chk("R3 pwr commit cd0", 4, 'h0000);
    idle(6);
    // R9: long period then mid-period change
    pwr_seq('h0005);
    idle(40);
    pwr_seq('h0001);
    idle(80);
    // R7
    pwr_seq('h0072);
    rd_chk("R7 reserved op kept cd updated", 4, 'h0002);
    // R10
    pwr_seq('h0031);
    rd_chk("R10 sleep entered", 4, 'h0031);
    @(posedge clk); #2; tmr = 1; @(posedge clk); #2; tmr = 0;
    rd_chk("R10 timer wakes sleep", 4, 'h0001);
    pwr_seq('h0031);
    @(posedge clk); #2; irq = 4'b0100; @(posedge clk); #2; irq = 0;
    rd_chk("R10 irq wakes sleep", 4, 'h0001);
    // R11
    pwr_seq('h0041);
    @(posedge clk); #2; tmr = 1; @(posedge clk); #2; tmr = 0;
    rd_chk("R11 timer ignored in stop", 4, 'h0041);
    @(posedge clk); #2; irq = 4'b0001; @(posedge clk); #2; irq = 0;
    rd_chk("R11 irq wakes stop", 4, 'h0001);
    pwr_seq('h0011);
    @(posedge clk); #2; irq = 4'b1111; tmr = 1; @(posedge clk); #2; irq = 0; tmr = 0;
    rd_chk("R11 pause not woken", 4, 'h0011);
    pwr_seq('h0021);
    @(posedge clk); #2; irq = 4'b1000; tmr = 1; @(posedge clk); #2; irq = 0; tmr = 0;
    rd_chk("R11 nap not woken", 4, 'h0021);
    idle(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule